// File: doc/BRIEF.md
# Posted-Write Error Capture Queue

This block keeps a record of each received physical write request whose payload could not be written into host memory because of a host bus error. Each record holds the requester's 16-bit source identifier and the 48-bit destination offset of the request. The records wait in a four-entry first-in first-out queue. An interrupt event output stays high while at least one record is waiting.

Software services the queue through two read-only registers and a clear strobe. It reads the high word, which carries the identifier and the top of the offset. It then reads the low word, which carries the rest of the offset. Finally it writes the clear strobe, and that removes the head record. If records still remain after the clear, the event output stays high, and software repeats the same sequence until the queue is empty. Reports that arrive while the queue is full are discarded, and a sticky overflow flag records that this happened.

Top module: `pw_err_capture`

## Requirements
- R1: After reset the event output `pw_err_evt_o` and the overflow flag `ovf_o` are both 0.
- R2: An error report (`err_valid_i` high for one cycle) is stored only while `pw_enable_i` is 1. While `pw_enable_i` is 0 a report changes neither the queue nor any output.
- R3: With `reg_addr_i` = 0, `reg_rdata_o` shows the high word of the head record: source ID in bits 31:16 and offset bits 47:32 in bits 15:0.
- R4: With `reg_addr_i` = 1, `reg_rdata_o` shows offset bits 31:0 of the head record.
- R5: An accepted report drives `pw_err_evt_o` to 1 on the clock edge that stores it.
- R6: A pulse on `evt_clear_i` removes the head record. `pw_err_evt_o` stays 1 while records remain and falls to 0 on the edge that removes the last one.
- R7: Reading either register any number of times leaves the queue and `pw_err_evt_o` unchanged.
- R8: Records leave the queue in the order they arrived, and the queue holds up to four records.
- R9: A report that arrives while four records are held and no clear is given is dropped, and `ovf_o` goes to 1. `ovf_o` stays 1 until the edge on which the queue becomes empty.
- R10: A report and a clear on the same cycle remove the old head and store the new record. `pw_err_evt_o` ends at 1.
- R11: A clear while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pw_enable_i | input | 1 | Enables capture of error reports |
| err_valid_i | input | 1 | Single-cycle strobe for an error report |
| err_src_id_i | input | 16 | Source ID of the failing request |
| err_offset_i | input | 48 | Destination offset of the failing request |
| reg_addr_i | input | 1 | Register select: 0 selects the high word, 1 selects the low word |
| reg_rdata_o | output | 32 | Selected word of the head record |
| evt_clear_i | input | 1 | Write-1 strobe that clears the event and removes the head record |
| pw_err_evt_o | output | 1 | Interrupt event: a record is pending |
| ovf_o | output | 1 | Sticky flag: a report was dropped |

## Verification
The tests send a single isolated report, and also reports sent while capture is disabled. These show whether the enable gate and the event set path work on their own. A burst of four distinct records followed by a fifth shows whether the queue keeps arrival order and where the full boundary lies. It also shows whether the overflow flag sets on the drop and clears only on the final drain. A clear given while the queue is empty, and a clear given on the same cycle as a new report, separate the case where the pop wins from the case where the push wins. Repeated register reads with no clear show that reads have no side effect.

// File: rtl/pw_err_pkg.sv
package pw_err_pkg;
  localparam int unsigned ID_W   = 16;
  localparam int unsigned OFS_W  = 48;
  localparam int unsigned DATA_W = 32;

  typedef struct packed {
    logic [ID_W-1:0]  src_id;
    logic [OFS_W-1:0] offset;
  } err_rec_t;
endpackage

// File: rtl/pw_err_fifo.sv
module pw_err_fifo
  import pw_err_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           push_i,
  input  err_rec_t                       rec_i,
  input  logic                           pop_i,
  output err_rec_t                       head_o,
  output logic [$clog2(DEPTH+1)-1:0]     level_o,
  output logic                           full_o,
  output logic                           empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH+1);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH-1);

  err_rec_t         mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] level_q;

  // storage has no reset: contents undefined until written
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push_i && wr_ptr_q == PTR_W'(g)) mem_q[g] <= rec_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign level_o = level_q;
  assign full_o  = (level_q == FULL_LVL);
  assign empty_o = (level_q == '0);

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));
  assert_no_underflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  assert_level_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= FULL_LVL);
endmodule

// File: rtl/pw_err_evt.sv
module pw_err_evt #(
  parameter int unsigned DEPTH = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic                       pop_i,
  input  logic                       drop_i,
  input  logic [$clog2(DEPTH+1)-1:0] level_i,
  output logic                       evt_o,
  output logic                       ovf_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic evt_q, ovf_q;
  logic last_pop;

  assign last_pop = pop_i && !push_i && (level_i == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (push_i)        evt_q <= 1'b1;
      else if (last_pop) evt_q <= 1'b0;
      if (drop_i)        ovf_q <= 1'b1;
      else if (last_pop) ovf_q <= 1'b0;
    end
  end

  assign evt_o = evt_q;
  assign ovf_o = ovf_q;

  assert_evt_on_push_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> evt_o);
  assert_evt_off_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_pop |=> !evt_o);
  assert_evt_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && level_i > ONE) |=> evt_o);
  assert_ovf_on_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> ovf_o);
endmodule

// File: rtl/pw_err_regmux.sv
module pw_err_regmux
  import pw_err_pkg::*;
(
  input  err_rec_t          head_i,
  input  logic              addr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned HI_OFS_W = OFS_W - DATA_W;

  logic [DATA_W-1:0] hi_word, lo_word;

  assign hi_word = {head_i.src_id, head_i.offset[OFS_W-1 -: HI_OFS_W]};
  assign lo_word = head_i.offset[DATA_W-1:0];
  assign rdata_o = addr_i ? lo_word : hi_word;

  initial begin
    assert_word_fit_R3: assert (ID_W + HI_OFS_W == DATA_W);
  end
endmodule

// File: rtl/pw_err_capture.sv
module pw_err_capture
  import pw_err_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pw_enable_i,
  input  logic              err_valid_i,
  input  logic [ID_W-1:0]   err_src_id_i,
  input  logic [OFS_W-1:0]  err_offset_i,
  input  logic              reg_addr_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              evt_clear_i,
  output logic              pw_err_evt_o,
  output logic              ovf_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  err_rec_t         in_rec, head;
  logic             capture, push, pop, drop, full, empty;
  logic [CNT_W-1:0] level;

  assign in_rec  = '{src_id: err_src_id_i, offset: err_offset_i};
  assign capture = err_valid_i && pw_enable_i;
  assign pop     = evt_clear_i && !empty;
  assign push    = capture && (!full || pop);
  assign drop    = capture && full && !pop;

  pw_err_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .rec_i   (in_rec),
    .pop_i   (pop),
    .head_o  (head),
    .level_o (level),
    .full_o  (full),
    .empty_o (empty)
  );

  pw_err_evt #(.DEPTH(DEPTH)) u_evt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .drop_i  (drop),
    .level_i (level),
    .evt_o   (pw_err_evt_o),
    .ovf_o   (ovf_o)
  );

  pw_err_regmux u_mux (
    .head_i  (head),
    .addr_i  (reg_addr_i),
    .rdata_o (reg_rdata_o)
  );

  assert_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pw_enable_i && !evt_clear_i) |=> $stable(level));
  assert_evt_tracks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pw_err_evt_o == !empty);
  assert_same_cycle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture && evt_clear_i && !empty) |=> (pw_err_evt_o && $stable(level)));
endmodule

// File: tb/tb_pw_err_capture.sv
module tb_pw_err_capture;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pw_enable_i = 1'b0;
  logic        err_valid_i = 1'b0;
  logic [15:0] err_src_id_i = '0;
  logic [47:0] err_offset_i = '0;
  logic        reg_addr_i = 1'b0;
  logic [31:0] reg_rdata_o;
  logic        evt_clear_i = 1'b0;
  logic        pw_err_evt_o, ovf_o;

  int checks = 0;
  int fails  = 0;
  logic [63:0] sb_q[$];

  always #2 clk_i = ~clk_i;

  pw_err_capture dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: sends a report and records the expected record
  task automatic send(input logic [15:0] id, input logic [47:0] ofs, input logic clr);
    err_src_id_i = id;
    err_offset_i = ofs;
    err_valid_i  = 1'b1;
    evt_clear_i  = clr;
    if (clr && sb_q.size() != 0) void'(sb_q.pop_front());
    if (pw_enable_i && sb_q.size() < 4) sb_q.push_back({id, ofs});
    @(negedge clk_i);
    err_valid_i = 1'b0;
    evt_clear_i = 1'b0;
  endtask

  // monitor: reads head through the registers and compares to the scoreboard
  task automatic service(input string req);
    logic [63:0] e;
    e = sb_q.pop_front();
    reg_addr_i = 1'b0; #1;
    chk({req, " R3 hi word"}, reg_rdata_o, e[63:32]);
    reg_addr_i = 1'b1; #1;
    chk({req, " R4 lo word"}, reg_rdata_o, e[31:0]);
    @(negedge clk_i);
    evt_clear_i = 1'b1;
    @(negedge clk_i);
    evt_clear_i = 1'b0;
    chk({req, " R6 evt after clear"}, pw_err_evt_o, sb_q.size() != 0);
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 evt at reset", pw_err_evt_o, 0);
    chk("R1 ovf at reset", ovf_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: disabled capture ignored
    send(16'hdead, 48'h1111_2222_3333, 1'b0);
    chk("R2 evt stays low", pw_err_evt_o, 0);
    pw_enable_i = 1'b1;

    // R5, R3, R4, R7
    send(16'h0a0b, 48'habcd_1234_5678, 1'b0);
    chk("R5 evt set", pw_err_evt_o, 1);
    for (int i = 0; i < 3; i++) begin
      reg_addr_i = 1'b0; #1;
      chk("R7 hi stable", reg_rdata_o, 32'h0a0b_abcd);
      reg_addr_i = 1'b1; #1;
      chk("R7 lo stable", reg_rdata_o, 32'h1234_5678);
      @(negedge clk_i);
    end
    chk("R7 evt unchanged", pw_err_evt_o, 1);
    service("R6 single");
    chk("R6 evt low when empty", pw_err_evt_o, 0);

    // R8, R9: fill, overflow, drain in order
    for (int i = 0; i < 5; i++)
      send(16'h1000 + 16'(i), 48'h0000_0100_0000 * 48'(i + 1) + 48'(i), 1'b0);
    chk("R8 evt with four", pw_err_evt_o, 1);
    chk("R9 ovf after drop", ovf_o, 1);
    for (int i = 0; i < 4; i++) begin
      service("R8 drain");
      chk("R9 ovf sticky until empty", ovf_o, i != 3);
    end

    // R11: clear on empty
    evt_clear_i = 1'b1;
    @(negedge clk_i);
    evt_clear_i = 1'b0;
    chk("R11 evt stays low", pw_err_evt_o, 0);
    chk("R11 ovf stays low", ovf_o, 0);
    send(16'h5555, 48'h0123_4567_89ab, 1'b0);
    chk("R11 queue not disturbed", pw_err_evt_o, 1);

    // R10: push and clear same cycle
    send(16'h7777, 48'hfeed_beef_cafe, 1'b1);
    chk("R10 evt set", pw_err_evt_o, 1);
    service("R10 new head");
    chk("R10 empty after", pw_err_evt_o, 0);

    // R2: disabled while holding a record
    send(16'h2222, 48'h0000_0000_0042, 1'b0);
    pw_enable_i = 1'b0;
    send(16'h3333, 48'h0000_0000_0099, 1'b0);
    service("R2 only enabled record");
    chk("R2 nothing extra", pw_err_evt_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule